// File: doc/BRIEF.md
# Gated Prescaled Period-Match Timer

This block is an up-counting timer with a period register, a divide-by-N prescaler and a sticky event flag. Each count step comes from one of two sources. The first is the internal bus clock, which can optionally be qualified by a gate input. The second is the rising edges of an external event input. The external input is sampled in the bus clock domain through a synchroniser. A control bit picks whether edge detection gets one extra alignment stage. When a prescaled step finds the counter equal to the period register, the counter returns to zero and the event flag is raised.

Software reaches the four registers through one write port: control, count, period and flag. Each write carries an operation code. The code can replace the addressed register, or clear, set or toggle only the bits that are 1 in the write data. All registers are visible on output ports, so the block can be used as a periodic tick source, a gated pulse-width accumulator or an external event counter.

Top module: `pm_timer`

## Requirements
- R1: After reset the control, count and period registers read 0 and the flag is 0.
- R2: The write port decodes address 0 as control, 1 as count, 2 as period and 3 as flag (bit 0 of the data). The operation code selects the update: 0 replaces the value, 1 clears the bits set in the data, 2 sets them, and 3 inverts them. Only the addressed register changes.
- R3: Control fields are: bit 15 enable, bit 7 gate enable, bits 5:4 prescaler select, bit 2 sync, and bit 1 source (0 = internal, 1 = external). All other control bits always read 0.
- R4: A count step is a prescaled tick. On each step, a counter equal to the period register becomes 0 and raises the flag; otherwise the counter increments. With period 0 the counter stays at 0 and the flag is raised on every step.
- R5: The flag stays set until it is cleared through address 3. A match or a gate falling edge in the same cycle as a clearing write leaves the flag set.
- R6: Prescaler select 00, 01, 10 and 11 give one count step per 1, 8, 64 and 256 source events.
- R7: With the internal source and gate enable set, a source event occurs only in cycles where gate_i is high. A high-to-low transition of gate_i raises the flag.
- R8: With the external source, each rising edge of ext_clk_i is one source event. gate_i and the gate enable bit then neither block counting nor raise the flag.
- R9: With the external source and sync = 0, a rising edge of ext_clk_i first sampled at clock edge k is counted at edge k+1. With sync = 1 it is counted at edge k+2.
- R10: While enable is 0 the counter does not move and the prescaler count is reset. On re-enable, a full prescale ratio of events is needed before the next step. Register contents are kept.
- R11: A write to the count register takes priority over a count step in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select (R2) |
| wr_op_i | input | 2 | Write operation: replace, clear, set, invert |
| wr_data_i | input | CNT_W | Write data / bit mask |
| ext_clk_i | input | 1 | External event input, sampled by clk_i |
| gate_i | input | 1 | Gate input for internal gated mode |
| ctrl_o | output | 16 | Control register |
| count_o | output | CNT_W | Counter value |
| period_o | output | CNT_W | Period register |
| flag_o | output | 1 | Sticky event flag |

## Verification
A corrupted prescaler count or a wrong synchroniser stage shows up as count_o stepping one or more cycles too early or too late. The bench therefore compares count_o and flag_o against a cycle-exact model after every clock edge, so the first misplaced step is reported in that same cycle. Alias decoding or masking faults show on ctrl_o and period_o one cycle after the write. A flag priority fault shows as flag_o reading 0 right after a clear that collided with a match.

// File: rtl/pm_timer_pkg.sv
package pm_timer_pkg;
  localparam int unsigned CTRL_W    = 16;
  localparam int unsigned BIT_ON    = 15;
  localparam int unsigned BIT_GATE  = 7;
  localparam int unsigned BIT_PS_LO = 4;
  localparam int unsigned BIT_SYNC  = 2;
  localparam int unsigned BIT_SRC   = 1;
  localparam logic [CTRL_W-1:0] CTRL_MASK = 16'h80B6;

  typedef enum logic [1:0] {OP_WRITE = 2'd0, OP_CLR = 2'd1, OP_SET = 2'd2, OP_INV = 2'd3} wr_op_e;
  typedef enum logic [1:0] {A_CTRL = 2'd0, A_COUNT = 2'd1, A_PERIOD = 2'd2, A_FLAG = 2'd3} reg_addr_e;

  typedef struct packed {
    logic       on;
    logic       gate_en;
    logic [1:0] ps;
    logic       sync;
    logic       ext_src;
  } ctrl_t;
endpackage

// File: rtl/pmt_alias.sv
module pmt_alias
  import pm_timer_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] old_i,
  input  logic [W-1:0] data_i,
  input  wr_op_e       op_i,
  output logic [W-1:0] new_o
);
  always_comb begin
    unique case (op_i)
      OP_WRITE: new_o = data_i;
      OP_CLR:   new_o = old_i & ~data_i;
      OP_SET:   new_o = old_i | data_i;
      default:  new_o = old_i ^ data_i;
    endcase
  end
endmodule

// File: rtl/pmt_regs.sv
module pmt_regs
  import pm_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  reg_addr_e         wr_addr_i,
  input  wr_op_e            wr_op_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  output logic [CTRL_W-1:0] ctrl_raw_o,
  output ctrl_t             ctrl_o,
  output logic [CNT_W-1:0]  period_o
);
  logic [CTRL_W-1:0] ctrl_q, ctrl_new;
  logic [CNT_W-1:0]  period_q, period_new;
  logic              ctrl_we, period_we;

  assign ctrl_we   = wr_en_i && (wr_addr_i == A_CTRL);
  assign period_we = wr_en_i && (wr_addr_i == A_PERIOD);

  pmt_alias #(.W(CTRL_W)) u_ctrl_alias (
    .old_i(ctrl_q), .data_i(wr_data_i[CTRL_W-1:0]), .op_i(wr_op_i), .new_o(ctrl_new)
  );
  pmt_alias #(.W(CNT_W)) u_period_alias (
    .old_i(period_q), .data_i(wr_data_i), .op_i(wr_op_i), .new_o(period_new)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      period_q <= '0;
    end else begin
      if (ctrl_we)   ctrl_q   <= ctrl_new & CTRL_MASK;
      if (period_we) period_q <= period_new;
    end
  end

  assign ctrl_raw_o      = ctrl_q;
  assign period_o        = period_q;
  assign ctrl_o.on       = ctrl_q[BIT_ON];
  assign ctrl_o.gate_en  = ctrl_q[BIT_GATE];
  assign ctrl_o.ps       = ctrl_q[BIT_PS_LO +: 2];
  assign ctrl_o.sync     = ctrl_q[BIT_SYNC];
  assign ctrl_o.ext_src  = ctrl_q[BIT_SRC];

  // R2: registers only move when addressed
  a_r2_ctrl_untouched: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_we |=> $stable(ctrl_q));
  a_r2_period_untouched: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !period_we |=> $stable(period_q));
endmodule

// File: rtl/pmt_tick.sv
module pmt_tick
  import pm_timer_pkg::*;
#(
  parameter int unsigned PRE_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  ctrl_t ctrl_i,
  input  logic  ext_i,
  input  logic  gate_i,
  output logic  tick_o,
  output logic  gate_fall_o
);
  localparam int unsigned SH_W = SYNC_STAGES + 1;

  logic [SH_W-1:0]  sh_q;
  logic             gate_q;
  logic [PRE_W-1:0] pre_q, pre_lim;
  logic             edge_fast, edge_slow, ext_evt, src_evt;

  function automatic logic [PRE_W-1:0] ratio_m1(input logic [1:0] ps);
    unique case (ps)
      2'd0:    return '0;
      2'd1:    return PRE_W'((1 << 3) - 1);
      2'd2:    return PRE_W'((1 << 6) - 1);
      default: return PRE_W'((1 << 8) - 1);
    endcase
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      gate_q <= 1'b0;
    end else begin
      sh_q   <= {sh_q[SH_W-2:0], ext_i};
      gate_q <= gate_i;
    end
  end

  // sync=0 skips the last alignment flop
  assign edge_fast = sh_q[SYNC_STAGES-2] & ~sh_q[SYNC_STAGES-1];
  assign edge_slow = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
  assign ext_evt   = ctrl_i.sync ? edge_slow : edge_fast;

  always_comb begin
    if (ctrl_i.ext_src)      src_evt = ext_evt;
    else if (ctrl_i.gate_en) src_evt = gate_i;
    else                     src_evt = 1'b1;
  end

  assign pre_lim = ratio_m1(ctrl_i.ps);
  assign tick_o  = ctrl_i.on && src_evt && (pre_q >= pre_lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 pre_q <= '0;
    else if (!ctrl_i.on || tick_o) pre_q <= '0;
    else if (src_evt)            pre_q <= pre_q + 1'b1;
  end

  assign gate_fall_o = ctrl_i.on && !ctrl_i.ext_src && ctrl_i.gate_en && gate_q && !gate_i;

  // R10: no step while disabled
  a_r10_off_no_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_i.on |-> !tick_o);
  // R10: prescaler count cleared while disabled
  a_r10_pre_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_i.on |=> pre_q == '0);
  // R8: gate has no effect with external source
  a_r8_no_fall_ext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_i.ext_src |-> !gate_fall_o);
endmodule

// File: rtl/pmt_core.sv
module pmt_core
  import pm_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             fall_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic             cnt_wr_i,
  input  logic             flag_wr_i,
  input  wr_op_e           wr_op_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic [CNT_W-1:0] count_o,
  output logic             flag_o
);
  logic [CNT_W-1:0] count_q, count_new;
  logic             flag_q, flag_new, match;

  pmt_alias #(.W(CNT_W)) u_count_alias (
    .old_i(count_q), .data_i(wr_data_i), .op_i(wr_op_i), .new_o(count_new)
  );
  pmt_alias #(.W(1)) u_flag_alias (
    .old_i(flag_q), .data_i(wr_data_i[0]), .op_i(wr_op_i), .new_o(flag_new)
  );

  assign match = tick_i && (count_q == period_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      flag_q  <= 1'b0;
    end else begin
      if (cnt_wr_i)    count_q <= count_new;
      else if (match)  count_q <= '0;
      else if (tick_i) count_q <= count_q + 1'b1;

      if (match || fall_i) flag_q <= 1'b1;
      else if (flag_wr_i)  flag_q <= flag_new;
    end
  end

  assign count_o = count_q;
  assign flag_o  = flag_q;

  a_r4_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && (count_q == period_i) && !cnt_wr_i |=> count_q == '0);
  a_r4_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && (count_q != period_i) && !cnt_wr_i |=> count_q == CNT_W'($past(count_q) + 1'b1));
  a_r5_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_q && !flag_wr_i |=> flag_q);
  a_r5_match_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && (count_q == period_i)) || fall_i |=> flag_q);
  a_r10_hold_without_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i && !cnt_wr_i |=> $stable(count_q));
endmodule

// File: rtl/pm_timer.sv
module pm_timer
  import pm_timer_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned PRE_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [1:0]        wr_op_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  input  logic              ext_clk_i,
  input  logic              gate_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [CNT_W-1:0]  count_o,
  output logic [CNT_W-1:0]  period_o,
  output logic              flag_o
);
  reg_addr_e        addr;
  wr_op_e           op;
  ctrl_t            ctrl;
  logic [CNT_W-1:0] period;
  logic             tick, fall;

  assign addr = reg_addr_e'(wr_addr_i);
  assign op   = wr_op_e'(wr_op_i);

  pmt_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i(addr), .wr_op_i(op), .wr_data_i,
    .ctrl_raw_o(ctrl_o), .ctrl_o(ctrl), .period_o(period)
  );

  pmt_tick #(.PRE_W(PRE_W), .SYNC_STAGES(SYNC_STAGES)) u_tick (
    .clk_i, .rst_ni, .ctrl_i(ctrl), .ext_i(ext_clk_i), .gate_i,
    .tick_o(tick), .gate_fall_o(fall)
  );

  pmt_core #(.CNT_W(CNT_W)) u_core (
    .clk_i, .rst_ni, .tick_i(tick), .fall_i(fall), .period_i(period),
    .cnt_wr_i(wr_en_i && (addr == A_COUNT)), .flag_wr_i(wr_en_i && (addr == A_FLAG)),
    .wr_op_i(op), .wr_data_i, .count_o, .flag_o
  );

  assign period_o = period;

  // R3: unimplemented control bits read 0
  a_r3_ctrl_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && (addr == A_CTRL) |=> (ctrl_o & ~CTRL_MASK) == '0);
endmodule

// File: tb/tb_pm_timer.sv
module tb_pm_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0, wr_op = '0;
  logic [15:0] wr_data = '0;
  logic        ext = 1'b0, gate = 1'b0;
  logic [15:0] ctrl_o, count_o, period_o;
  logic        flag_o;

  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  pm_timer dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_op_i(wr_op),
    .wr_data_i(wr_data), .ext_clk_i(ext), .gate_i(gate),
    .ctrl_o(ctrl_o), .count_o(count_o), .period_o(period_o), .flag_o(flag_o)
  );

  // reference model state
  logic [15:0] m_ctrl = '0, m_count = '0, m_period = '0;
  logic        m_flag = 1'b0, m_e1 = 1'b0, m_e2 = 1'b0, m_e3 = 1'b0, m_gq = 1'b0;
  int          m_pre = 0;
  logic        m_on, m_edge, m_evt, m_fall, m_tick, m_match;
  logic [15:0] m_tmp;

  function automatic logic [15:0] alias_f(input logic [15:0] o, input logic [15:0] d, input logic [1:0] op);
    case (op)
      2'd0: return d;
      2'd1: return o & ~d;
      2'd2: return o | d;
      default: return o ^ d;
    endcase
  endfunction

  function automatic int ratio_f(input logic [1:0] ps);
    case (ps)
      2'd0: return 1;
      2'd1: return 8;
      2'd2: return 64;
      default: return 256;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = '0; m_count = '0; m_period = '0; m_flag = 1'b0;
      m_e1 = 1'b0; m_e2 = 1'b0; m_e3 = 1'b0; m_gq = 1'b0; m_pre = 0;
    end else begin
      m_on   = m_ctrl[15];
      m_edge = m_ctrl[2] ? (m_e2 & ~m_e3) : (m_e1 & ~m_e2);
      m_evt  = m_on && (m_ctrl[1] ? m_edge : (m_ctrl[7] ? gate : 1'b1));
      m_fall = m_on && !m_ctrl[1] && m_ctrl[7] && m_gq && !gate;
      m_tick = 1'b0;
      if (!m_on) m_pre = 0;
      else if (m_evt) begin
        if (m_pre >= ratio_f(m_ctrl[5:4]) - 1) begin m_pre = 0; m_tick = 1'b1; end
        else m_pre = m_pre + 1;
      end
      m_match = m_tick && (m_count == m_period);
      if (m_match || m_fall) m_flag = 1'b1;
      else if (wr_en && wr_addr == 2'd3) begin
        m_tmp = alias_f({15'd0, m_flag}, wr_data, wr_op);
        m_flag = m_tmp[0];
      end
      if (wr_en && wr_addr == 2'd1) m_count = alias_f(m_count, wr_data, wr_op);
      else if (m_match) m_count = '0;
      else if (m_tick) m_count = m_count + 16'd1;
      if (wr_en && wr_addr == 2'd0) m_ctrl = alias_f(m_ctrl, wr_data, wr_op) & 16'h80B6;
      if (wr_en && wr_addr == 2'd2) m_period = alias_f(m_period, wr_data, wr_op);
      m_e3 = m_e2; m_e2 = m_e1; m_e1 = ext; m_gq = gate;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic cmp_model();
    chk(count_o == m_count, "R4", "count vs model", count_o, m_count);
    chk(flag_o == m_flag, "R5", "flag vs model", flag_o, m_flag);
    chk(ctrl_o == m_ctrl, "R3", "ctrl vs model", ctrl_o, m_ctrl);
    chk(period_o == m_period, "R2", "period vs model", period_o, m_period);
  endtask

  // drive at a negedge, let one posedge pass, compare at the next negedge
  task automatic step(input logic en, input logic [1:0] a, input logic [1:0] op,
                      input logic [15:0] d, input logic e, input logic g);
    wr_en = en; wr_addr = a; wr_op = op; wr_data = d; ext = e; gate = g;
    @(negedge clk);
    cmp_model();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 2'd0, 2'd0, 16'd0, ext, gate);
  endtask

  task automatic wr(input logic [1:0] a, input logic [1:0] op, input logic [15:0] d);
    step(1'b1, a, op, d, ext, gate);
  endtask

  logic [15:0] c0;

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1
    chk(ctrl_o == 16'h0 && count_o == 16'h0 && period_o == 16'h0 && flag_o == 1'b0,
        "R1", "reset state", {ctrl_o[7:0], count_o[7:0]}, 0);
    idle(2);

    // R3: only implemented bits stick; R2 clear alias
    wr(2'd0, 2'd0, 16'hFFFF);
    chk(ctrl_o == 16'h80B6, "R3", "ctrl mask", ctrl_o, 16'h80B6);
    wr(2'd0, 2'd1, 16'hFFFF);
    chk(ctrl_o == 16'h0, "R2", "ctrl clear alias", ctrl_o, 0);
    wr(2'd1, 2'd0, 16'h0);
    // R2 set / invert on period, others untouched
    wr(2'd2, 2'd0, 16'h00F0);
    wr(2'd2, 2'd2, 16'h0003);
    chk(period_o == 16'h00F3, "R2", "period set alias", period_o, 16'h00F3);
    wr(2'd2, 2'd3, 16'h0011);
    chk(period_o == 16'h00E2, "R2", "period invert alias", period_o, 16'h00E2);
    chk(count_o == 16'h0 && ctrl_o == 16'h0, "R2", "unaddressed regs kept", count_o, 0);

    // R4: period zero
    wr(2'd2, 2'd0, 16'h0000);
    wr(2'd0, 2'd0, 16'h8000);
    idle(3);
    chk(count_o == 16'h0, "R4", "period 0 count", count_o, 0);
    chk(flag_o == 1'b1, "R4", "period 0 flag", flag_o, 1);
    // R5: clear colliding with match loses
    wr(2'd3, 2'd1, 16'h0001);
    chk(flag_o == 1'b1, "R5", "match beats clear", flag_o, 1);
    // R11: count write beats tick
    wr(2'd1, 2'd0, 16'h0005);
    chk(count_o == 16'h5, "R11", "write beats tick", count_o, 5);
    wr(2'd0, 2'd1, 16'h8000);
    wr(2'd3, 2'd1, 16'h0001);
    chk(flag_o == 1'b0, "R5", "flag cleared", flag_o, 0);
    idle(2);
    chk(flag_o == 1'b0, "R5", "flag stays clear", flag_o, 0);

    // R6: divide by 8
    wr(2'd1, 2'd0, 16'h0000);
    wr(2'd2, 2'd0, 16'hFFFF);
    wr(2'd0, 2'd0, 16'h8010);
    idle(15);
    chk(count_o == 16'd1, "R6", "div8 after 15", count_o, 1);
    idle(1);
    chk(count_o == 16'd2, "R6", "div8 after 16", count_o, 2);

    // R10: disable resets prescaler and freezes counter
    idle(5);
    wr(2'd0, 2'd1, 16'h8000);
    c0 = count_o;
    idle(10);
    chk(count_o == c0, "R10", "frozen while off", count_o, c0);
    chk(period_o == 16'hFFFF, "R10", "period kept", period_o, 16'hFFFF);
    wr(2'd0, 2'd2, 16'h8000);
    idle(7);
    chk(count_o == c0, "R10", "full ratio needed", count_o, c0);
    idle(1);
    chk(count_o == c0 + 16'd1, "R10", "step after ratio", count_o, c0 + 1);

    // R7: gated mode
    wr(2'd0, 2'd0, 16'h0000);
    wr(2'd1, 2'd0, 16'h0000);
    wr(2'd0, 2'd0, 16'h8080);
    idle(3);
    chk(count_o == 16'd0, "R7", "gate low blocks", count_o, 0);
    for (int i = 0; i < 4; i++) step(1'b0, 2'd0, 2'd0, 16'd0, 1'b0, 1'b1);
    chk(count_o == 16'd4, "R7", "gate high counts", count_o, 4);
    chk(flag_o == 1'b0, "R7", "no flag while high", flag_o, 0);
    step(1'b0, 2'd0, 2'd0, 16'd0, 1'b0, 1'b0);
    chk(flag_o == 1'b1, "R7", "gate fall flag", flag_o, 1);
    wr(2'd3, 2'd0, 16'h0000);

    // R8 / R9: external, sync = 0, gate bit set but ignored
    wr(2'd0, 2'd0, 16'h8082);
    idle(3);
    c0 = count_o;
    step(1'b0, 2'd0, 2'd0, 16'd0, 1'b1, 1'b1);
    chk(count_o == c0, "R9", "sync0 not yet", count_o, c0);
    step(1'b0, 2'd0, 2'd0, 16'd0, 1'b1, 1'b0);
    chk(count_o == c0 + 16'd1, "R9", "sync0 edge k+1", count_o, c0 + 1);
    chk(flag_o == 1'b0, "R8", "gate fall ignored", flag_o, 0);
    step(1'b0, 2'd0, 2'd0, 16'd0, 1'b0, 1'b0);
    idle(3);
    chk(count_o == c0 + 16'd1, "R8", "one count per edge", count_o, c0 + 1);
    // sync = 1
    wr(2'd0, 2'd2, 16'h0004);
    idle(3);
    c0 = count_o;
    step(1'b0, 2'd0, 2'd0, 16'd0, 1'b1, 1'b0);
    step(1'b0, 2'd0, 2'd0, 16'd0, 1'b1, 1'b0);
    chk(count_o == c0, "R9", "sync1 not at k+1", count_o, c0);
    step(1'b0, 2'd0, 2'd0, 16'd0, 1'b1, 1'b0);
    chk(count_o == c0 + 16'd1, "R9", "sync1 edge k+2", count_o, c0 + 1);
    step(1'b0, 2'd0, 2'd0, 16'd0, 1'b0, 1'b0);

    // random mix against the model
    for (int i = 0; i < 4000; i++) begin
      logic        en;
      logic [1:0]  a, op;
      logic [15:0] d;
      logic        e, g;
      en = ($urandom % 10) == 0;
      a  = 2'($urandom);
      op = 2'($urandom);
      d  = 16'($urandom);
      if (a == 2'd0 && ($urandom % 4) != 0) begin
        op = 2'd0;
        d  = (d & 16'h00A6) | 16'h8000;
        if (($urandom % 3) != 0) d[5:4] = 2'd0;
      end
      if (a == 2'd2 || a == 2'd1) d = d & 16'h000F;
      e = (($urandom % 3) == 0) ? ~ext : ext;
      g = (($urandom % 4) == 0) ? ~gate : gate;
      step(en, a, op, d, e, g);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule